// File: doc/BRIEF.md
# Message Object Transfer Controller

This block copies field groups between a host-side interface buffer and one entry of a message-object store, as found in a CAN controller. The host presents a command: an object number, a direction bit and a five-bit mask. In the write direction the buffer contents go into the object. In the read direction the object contents go into a read-back buffer. Each mask bit enables one field group (arbitration, control, data) or one side action on the object's status flags.

Every accepted command runs as a read-modify-write of the selected store word. The block is busy for exactly two cycles and then pulses `done`. While busy, any new command is ignored. An object number of 0, or one above the configured count, runs the same busy sequence but does not touch the store or the read-back buffer, and it raises `err`.

Top module: `msg_obj_xfer`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly two cycles. `done` is high for the one cycle after `busy` falls.
- R2: A command presented while `busy` is high is ignored. The transfer in progress uses only the values captured at acceptance.
- R3: In a write with mask bit 0 (arbitration) set, the whole arbitration group of the object is replaced from the buffer. With that bit clear, the object's arbitration group is unchanged. Arbitration layout: bits [ID_W-1:0] identifier, bit ID_W direction, bit ID_W+1 extended-identifier, bit ID_W+2 message-valid.
- R4: In a write with mask bit 1 (control) set, the object's control group is replaced from the buffer. With that bit clear, the group is unchanged. Control layout: bits [CTL_W-1:0] length/mode, bit CTL_W new-data, bit CTL_W+1 transmit-request, bit CTL_W+2 interrupt-pending.
- R5: Mask bit 4 (data) moves the data group in the selected direction. With that bit clear, neither side's data changes.
- R6: In a read, each of the arbitration, control and data groups is copied into the read-back buffer when its mask bit is set. A group whose mask bit is clear keeps its previous read-back value.
- R7: Mask bit 2 clears the object's interrupt-pending flag in either direction. In a write, this clear takes precedence over the value copied in by the control group.
- R8: In a write, mask bit 3 sets the object's transmit-request flag, whatever the buffer's transmit-request bit holds.
- R9: In a read, mask bit 3 clears the object's new-data flag.
- R10: When a read also clears interrupt-pending or new-data, the read-back control group shows the flag values from before the clear.
- R11: Object number 0, or any number above NUM_OBJ, writes nothing to the store and leaves the read-back buffer unchanged. It still gives the two-cycle busy sequence, and `err` is high together with `done`. A valid command clears `err`.
- R12: A command with mask 0 changes neither the object nor the read-back buffer, and it still runs the full busy sequence.
- R13: After reset, every object, every read-back field, `busy`, `done` and `err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1: buffer to object, 0: object to read-back buffer |
| cmd_obj | input | IDX_W | Object number, 1..NUM_OBJ valid |
| cmd_mask | input | 5 | Group and side-action enables |
| wbuf_arb | input | ID_W+3 | Buffer arbitration group |
| wbuf_ctl | input | CTL_W+3 | Buffer control group |
| wbuf_dat | input | DATA_W | Buffer data group |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command had an invalid object number |
| rbuf_arb | output | ID_W+3 | Read-back arbitration group |
| rbuf_ctl | output | CTL_W+3 | Read-back control group |
| rbuf_dat | output | DATA_W | Read-back data group |

## Verification
The assertions assume that `rst_n` is low across the first clock edges and that the command inputs hold known values on every edge. They do not assume `cmd_valid` is low while busy. The stimulus deliberately drives a different, full-mask write on every busy cycle, so rejection is exercised on every transfer. The sweep covers every 3-bit object number (valid and invalid), all 32 masks and both directions. Inputs change only on falling edges.

// File: rtl/mot_pkg.sv
package mot_pkg;
   localparam int MSK_W      = 5;
   localparam int MSK_ARB    = 0;
   localparam int MSK_CTL    = 1;
   localparam int MSK_CLRINT = 2;
   localparam int MSK_TXND   = 3;
   localparam int MSK_DAT    = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WBACK = 2'd2
   } xfer_state_e;
endpackage

// File: rtl/mot_obj_decode.sv
module mot_obj_decode #(
   parameter int NUM_OBJ = 8,
   parameter int IDX_W   = 4,
   parameter int AW      = 3
) (
   input  logic [IDX_W-1:0] obj,
   output logic             ok,
   output logic [AW-1:0]    addr
);
   always_comb begin
      ok   = (obj != '0) && (obj <= IDX_W'(NUM_OBJ));
      addr = obj[AW-1:0] - AW'(1);
   end
endmodule

// File: rtl/mot_obj_store.sv
module mot_obj_store #(
   parameter int DEPTH     = 8,
   parameter int WIDTH     = 16,
   parameter int AW        = 3,
   parameter bit RESET_RAM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   generate
      if (RESET_RAM) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/mot_field_merge.sv
module mot_field_merge
   import mot_pkg::*;
#(
   parameter int ID_W   = 29,
   parameter int CTL_W  = 4,
   parameter int DATA_W = 64
) (
   input  logic              wr,
   input  logic [MSK_W-1:0]  mask,
   input  logic [ID_W+2:0]   obj_arb,
   input  logic [CTL_W+2:0]  obj_ctl,
   input  logic [DATA_W-1:0] obj_dat,
   input  logic [ID_W+2:0]   buf_arb,
   input  logic [CTL_W+2:0]  buf_ctl,
   input  logic [DATA_W-1:0] buf_dat,
   input  logic [ID_W+2:0]   prev_arb,
   input  logic [CTL_W+2:0]  prev_ctl,
   input  logic [DATA_W-1:0] prev_dat,
   output logic [ID_W+2:0]   new_arb,
   output logic [CTL_W+2:0]  new_ctl,
   output logic [DATA_W-1:0] new_dat,
   output logic [ID_W+2:0]   rb_arb,
   output logic [CTL_W+2:0]  rb_ctl,
   output logic [DATA_W-1:0] rb_dat
);
   localparam int B_NEWDAT = CTL_W;
   localparam int B_TXRQ   = CTL_W + 1;
   localparam int B_INTP   = CTL_W + 2;

   always_comb begin
      new_arb = obj_arb;
      new_ctl = obj_ctl;
      new_dat = obj_dat;
      rb_arb  = prev_arb;
      rb_ctl  = prev_ctl;
      rb_dat  = prev_dat;
      if (wr) begin
         if (mask[MSK_ARB]) new_arb = buf_arb;
         if (mask[MSK_CTL]) new_ctl = buf_ctl;
         if (mask[MSK_DAT]) new_dat = buf_dat;
         if (mask[MSK_TXND]) new_ctl[B_TXRQ] = 1'b1;
      end else begin
         // read-back receives the object's pre-clear flags
         if (mask[MSK_ARB]) rb_arb = obj_arb;
         if (mask[MSK_CTL]) rb_ctl = obj_ctl;
         if (mask[MSK_DAT]) rb_dat = obj_dat;
         if (mask[MSK_TXND]) new_ctl[B_NEWDAT] = 1'b0;
      end
      if (mask[MSK_CLRINT]) new_ctl[B_INTP] = 1'b0;
   end
endmodule

// File: rtl/msg_obj_xfer.sv
module msg_obj_xfer
   import mot_pkg::*;
#(
   parameter int NUM_OBJ   = 8,
   parameter int IDX_W     = 4,
   parameter int ID_W      = 29,
   parameter int CTL_W     = 4,
   parameter int DATA_W    = 64,
   parameter bit RESET_RAM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [IDX_W-1:0]  cmd_obj,
   input  logic [4:0]        cmd_mask,
   input  logic [ID_W+2:0]   wbuf_arb,
   input  logic [CTL_W+2:0]  wbuf_ctl,
   input  logic [DATA_W-1:0] wbuf_dat,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [ID_W+2:0]   rbuf_arb,
   output logic [CTL_W+2:0]  rbuf_ctl,
   output logic [DATA_W-1:0] rbuf_dat
);
   localparam int ARB_W = ID_W + 3;
   localparam int CV_W  = CTL_W + 3;
   localparam int OBJ_W = DATA_W + CV_W + ARB_W;
   localparam int AW    = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1;

   generate
      if (NUM_OBJ < 1) begin : g_bad_num
         $error("NUM_OBJ must be at least 1");
      end
      if (IDX_W < $clog2(NUM_OBJ + 1) || IDX_W < AW) begin : g_bad_idx
         $error("IDX_W too narrow for NUM_OBJ");
      end
      if (ID_W < 1 || CTL_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("field widths must be positive");
      end
   endgenerate

   xfer_state_e       state;
   logic              wr_q;
   logic [MSK_W-1:0]  mask_q;
   logic [IDX_W-1:0]  obj_q;
   logic [ID_W+2:0]   wa_q;
   logic [CTL_W+2:0]  wc_q;
   logic [DATA_W-1:0] wd_q;
   logic              idx_ok;
   logic [AW-1:0]     addr;
   logic [OBJ_W-1:0]  rd_word;
   logic [ID_W+2:0]   new_arb, rb_arb;
   logic [CTL_W+2:0]  new_ctl, rb_ctl;
   logic [DATA_W-1:0] new_dat, rb_dat;
   logic              ram_re, ram_we;

   mot_obj_decode #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W), .AW(AW)) u_dec (
      .obj(obj_q), .ok(idx_ok), .addr(addr)
   );

   assign ram_re = (state == ST_READ) && idx_ok;
   assign ram_we = (state == ST_WBACK) && idx_ok && wr_q;

   mot_obj_store #(.DEPTH(NUM_OBJ), .WIDTH(OBJ_W), .AW(AW), .RESET_RAM(RESET_RAM)) u_store (
      .clk(clk), .rst_n(rst_n), .re(ram_re), .raddr(addr), .rdata(rd_word),
      .we(ram_we || ((state == ST_WBACK) && idx_ok && !wr_q)),
      .waddr(addr), .wdata({new_dat, new_ctl, new_arb})
   );

   mot_field_merge #(.ID_W(ID_W), .CTL_W(CTL_W), .DATA_W(DATA_W)) u_merge (
      .wr(wr_q), .mask(mask_q),
      .obj_arb(rd_word[ARB_W-1:0]),
      .obj_ctl(rd_word[ARB_W +: CV_W]),
      .obj_dat(rd_word[ARB_W+CV_W +: DATA_W]),
      .buf_arb(wa_q), .buf_ctl(wc_q), .buf_dat(wd_q),
      .prev_arb(rbuf_arb), .prev_ctl(rbuf_ctl), .prev_dat(rbuf_dat),
      .new_arb(new_arb), .new_ctl(new_ctl), .new_dat(new_dat),
      .rb_arb(rb_arb), .rb_ctl(rb_ctl), .rb_dat(rb_dat)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         wr_q     <= 1'b0;
         mask_q   <= '0;
         obj_q    <= '0;
         wa_q     <= '0;
         wc_q     <= '0;
         wd_q     <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         rbuf_arb <= '0;
         rbuf_ctl <= '0;
         rbuf_dat <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               wr_q   <= cmd_write;
               mask_q <= cmd_mask;
               obj_q  <= cmd_obj;
               wa_q   <= wbuf_arb;
               wc_q   <= wbuf_ctl;
               wd_q   <= wbuf_dat;
               err    <= 1'b0;
               state  <= ST_READ;
            end
            ST_READ: state <= ST_WBACK;
            ST_WBACK: begin
               state <= ST_IDLE;
               done  <= 1'b1;
               err   <= !idx_ok;
               if (idx_ok && !wr_q) begin
                  rbuf_arb <= rb_arb;
                  rbuf_ctl <= rb_ctl;
                  rbuf_dat <= rb_dat;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: two-cycle busy window, done right after it
   a_r1_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);
   a_r1_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |=> !busy);
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R2: captured command frozen while busy
   a_r2_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(obj_q) && $stable(mask_q) && $stable(wr_q)));
   // R11: error flag tracks the object number; read-back untouched
   a_r11_err_match: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err == !idx_ok));
   a_r11_rbuf_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> ($stable(rbuf_arb) && $stable(rbuf_ctl) && $stable(rbuf_dat)));
   // R8: write side action forces transmit request into the stored word
   a_r8_txrq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && mask_q[MSK_TXND]) |-> new_ctl[CTL_W+1]);
   // R9: read side action clears new-data in the stored word
   a_r9_newdat_clr: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_WBACK) && idx_ok && !wr_q && mask_q[MSK_TXND]) |-> !new_ctl[CTL_W]);
   // R10: read-back control equals the word read before side actions
   a_r10_preclear: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && !wr_q && mask_q[MSK_CTL]) |-> (rbuf_ctl == rd_word[ARB_W +: CV_W]));
endmodule

// File: tb/msg_obj_xfer_tb.sv
module msg_obj_xfer_tb;
   localparam int NOBJ = 4;
   localparam int IW   = 3;
   localparam int IDW  = 5;
   localparam int CW   = 2;
   localparam int DW   = 8;
   localparam int AWD  = IDW + 3;
   localparam int CVW  = CW + 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [IW-1:0]  cmd_obj = '0;
   logic [4:0]     cmd_mask = '0;
   logic [AWD-1:0] wbuf_arb = '0;
   logic [CVW-1:0] wbuf_ctl = '0;
   logic [DW-1:0]  wbuf_dat = '0;
   logic           busy, done, err;
   logic [AWD-1:0] rbuf_arb;
   logic [CVW-1:0] rbuf_ctl;
   logic [DW-1:0]  rbuf_dat;

   int n_chk = 0, n_fail = 0;

   logic [AWD-1:0] m_arb [1:NOBJ];
   logic [CVW-1:0] m_ctl [1:NOBJ];
   logic [DW-1:0]  m_dat [1:NOBJ];
   logic [AWD-1:0] e_arb;
   logic [CVW-1:0] e_ctl;
   logic [DW-1:0]  e_dat;

   always #5 clk = ~clk;

   msg_obj_xfer #(.NUM_OBJ(NOBJ), .IDX_W(IW), .ID_W(IDW), .CTL_W(CW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_obj(cmd_obj), .cmd_mask(cmd_mask), .wbuf_arb(wbuf_arb), .wbuf_ctl(wbuf_ctl),
      .wbuf_dat(wbuf_dat), .busy(busy), .done(done), .err(err),
      .rbuf_arb(rbuf_arb), .rbuf_ctl(rbuf_ctl), .rbuf_dat(rbuf_dat)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_cmd(input bit wr, input logic [IW-1:0] o, input logic [4:0] m,
                         input logic [AWD-1:0] a, input logic [CVW-1:0] c,
                         input logic [DW-1:0] d, input string tg);
      bit ok;
      ok = (o != 0) && (o <= NOBJ);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = wr; cmd_obj = o; cmd_mask = m;
      wbuf_arb = a; wbuf_ctl = c; wbuf_dat = d;
      if (ok) begin
         if (wr) begin
            if (m[0]) m_arb[o] = a;
            if (m[1]) m_ctl[o] = c;
            if (m[4]) m_dat[o] = d;
            if (m[3]) m_ctl[o][CW+1] = 1'b1;
         end else begin
            if (m[0]) e_arb = m_arb[o];
            if (m[1]) e_ctl = m_ctl[o];
            if (m[4]) e_dat = m_dat[o];
            if (m[3]) m_ctl[o][CW] = 1'b0;
         end
         if (m[2]) m_ctl[o][CW+2] = 1'b0;
      end
      @(negedge clk);
      chk(busy === 1'b1, "R1 busy cycle 1", 64'(busy), 64'd1);
      // R2: a different full-mask write to object 1 is held on the inputs while busy
      cmd_write = 1'b1; cmd_obj = 3'd1; cmd_mask = 5'h1F;
      wbuf_arb = '1; wbuf_ctl = '1; wbuf_dat = 8'h5A;
      @(negedge clk);
      chk(busy === 1'b1, "R1 busy cycle 2", 64'(busy), 64'd1);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(!busy && done, "R1 done after busy", {62'd0, busy, done}, 64'd1);
      chk(err === !ok, "R11 err flag", 64'(err), 64'(!ok));
      chk(rbuf_arb === e_arb, {tg, " rbuf arb"}, 64'(rbuf_arb), 64'(e_arb));
      chk(rbuf_ctl === e_ctl, {tg, " rbuf ctl"}, 64'(rbuf_ctl), 64'(e_ctl));
      chk(rbuf_dat === e_dat, {tg, " rbuf data"}, 64'(rbuf_dat), 64'(e_dat));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 1; i <= NOBJ; i++) begin m_arb[i] = '0; m_ctl[i] = '0; m_dat[i] = '0; end
      e_arb = '0; e_ctl = '0; e_dat = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err, "R13 reset flags", {61'd0, busy, done, err}, 64'd0);
      chk(rbuf_arb == 0 && rbuf_ctl == 0 && rbuf_dat == 0, "R13 reset rbuf",
          64'({rbuf_arb, rbuf_ctl, rbuf_dat}), 64'd0);
      for (int o = 1; o <= NOBJ; o++) do_cmd(1'b0, IW'(o), 5'h13, '0, '0, '0, "R13");

      // R3: arbitration only
      do_cmd(1'b1, 3'd2, 5'h01, 8'hA5, 5'h1F, 8'h3C, "R3");
      do_cmd(1'b0, 3'd2, 5'h13, '0, '0, '0, "R3");
      chk(rbuf_arb == 8'hA5, "R3 arb written", 64'(rbuf_arb), 64'hA5);
      chk(rbuf_ctl == 5'h00 && rbuf_dat == 8'h00, "R4 ctl/data untouched",
          64'({rbuf_ctl, rbuf_dat}), 64'd0);
      // R4/R5: control and data
      do_cmd(1'b1, 3'd2, 5'h12, 8'h00, 5'h1F, 8'h3C, "R4");
      do_cmd(1'b0, 3'd2, 5'h13, '0, '0, '0, "R5");
      chk(rbuf_ctl == 5'h1F, "R4 ctl written", 64'(rbuf_ctl), 64'h1F);
      chk(rbuf_dat == 8'h3C, "R5 data written", 64'(rbuf_dat), 64'h3C);
      chk(rbuf_arb == 8'hA5, "R3 arb kept on ctl write", 64'(rbuf_arb), 64'hA5);
      // R10/R7/R9: read with both clears reports pre-clear flags
      do_cmd(1'b0, 3'd2, 5'h0E, '0, '0, '0, "R10");
      chk(rbuf_ctl == 5'h1F, "R10 pre-clear flags", 64'(rbuf_ctl), 64'h1F);
      do_cmd(1'b0, 3'd2, 5'h02, '0, '0, '0, "R9");
      chk(rbuf_ctl == 5'h0B, "R7 R9 flags cleared", 64'(rbuf_ctl), 64'h0B);
      // R8: transmit request forced despite buffer bit 0
      do_cmd(1'b1, 3'd3, 5'h0A, '0, 5'h00, '0, "R8");
      do_cmd(1'b0, 3'd3, 5'h02, '0, '0, '0, "R8");
      chk(rbuf_ctl == 5'h08, "R8 txrqst set", 64'(rbuf_ctl), 64'h08);
      // R7: clear wins over copied interrupt-pending in a write
      do_cmd(1'b1, 3'd3, 5'h06, '0, 5'h10, '0, "R7");
      do_cmd(1'b0, 3'd3, 5'h02, '0, '0, '0, "R7");
      chk(rbuf_ctl == 5'h00, "R7 write clear wins", 64'(rbuf_ctl), 64'h00);
      // R12: zero mask
      do_cmd(1'b0, 3'd2, 5'h00, '0, '0, '0, "R12");
      chk(rbuf_ctl == 5'h00, "R12 rbuf unchanged", 64'(rbuf_ctl), 64'h00);
      do_cmd(1'b1, 3'd2, 5'h00, 8'hFF, 5'h1F, 8'hFF, "R12");
      // R11: invalid numbers do not alias onto real objects
      do_cmd(1'b1, 3'd0, 5'h1F, 8'h77, 5'h07, 8'h99, "R11");
      do_cmd(1'b1, 3'd5, 5'h1F, 8'h66, 5'h07, 8'h88, "R11");
      do_cmd(1'b0, 3'd7, 5'h13, '0, '0, '0, "R11");
      chk(rbuf_ctl == 5'h00, "R11 rbuf unchanged", 64'(rbuf_ctl), 64'h00);
      do_cmd(1'b0, 3'd4, 5'h13, '0, '0, '0, "R11");
      chk({rbuf_arb, rbuf_ctl, rbuf_dat} == 0, "R11 obj4 clean", 64'({rbuf_arb, rbuf_ctl, rbuf_dat}), 64'd0);
      do_cmd(1'b0, 3'd1, 5'h13, '0, '0, '0, "R2");
      chk({rbuf_arb, rbuf_ctl, rbuf_dat} == 0, "R2 busy commands ignored",
          64'({rbuf_arb, rbuf_ctl, rbuf_dat}), 64'd0);
      do_cmd(1'b0, 3'd2, 5'h13, '0, '0, '0, "R12");
      chk(rbuf_arb == 8'hA5 && rbuf_dat == 8'h3C, "R12 object unchanged",
          64'({rbuf_arb, rbuf_dat}), 64'hA53C);

      // sweep: every object number, mask and direction
      for (int o = 0; o < 8; o++) begin
         for (int m = 0; m < 32; m++) begin
            for (int w = 1; w >= 0; w--) begin
               string tg;
               tg = (m == 0) ? "R12" : (((o == 0) || (o > NOBJ)) ? "R11" : (w != 0 ? "R5" : "R6"));
               do_cmd(w[0], IW'(o), 5'(m), AWD'($urandom), CVW'($urandom), DW'($urandom), tg);
            end
         end
      end
      for (int o = 1; o <= NOBJ; o++) do_cmd(1'b0, IW'(o), 5'h13, '0, '0, '0, "R6");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule